// File: doc/BRIEF.md
# Multi-Rail Power Sequencing Controller

This block is the digital on/off control for a supply chip that carries two switching converters and four linear regulators. A master power-on request brings the rails up in a fixed order. The first converter comes up first, then the second converter, then the first linear rail. Each gap is timed in ticks of a slow time base. Linear rails 2 to 4 follow their own enable inputs, but only once the first linear rail reports power-good. Each of them then waits its own short delay before it turns on.

On shutdown, or when the supply falls below the falling undervoltage limit, every rail drops together except the first converter. That converter is held on for a further timed window, so it is always the first rail on and the last rail off. An active-low system reset follows the first linear rail's power-good and is released only after a long qualification delay. A rail-voltage select code, built from two tri-level pins, is latched once per power-up. Two fault inputs each shut one rail group while they are asserted.

Every delay is a parameter counted in ticks, so a bench can shrink the long reset window.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While reset is applied, every rail enable is low, the system reset output is low and the latched select code is 0.
- R2: A sequence starts only when power-on, the rising undervoltage flag and the falling undervoltage flag are all high. Converter 1 enables D_CONV1 ticks after the start edge.
- R3: Converter 2 enables D_CONV2 ticks after converter 1, and linear rail 1 enables D_LIN1 ticks after converter 2. Converter 2 is never on without converter 1.
- R4: Linear rails 2 to 4 can only be on while linear rail 1 is on and its power-good input is high. Once requested, rail 2 enables after D_LIN2 ticks and rails 3 and 4 after D_LIN34 ticks. A rail drops in the same cycle its request is removed.
- R5: The rail 2 enable input is active-low (high disables the rail). The rail 3 and rail 4 inputs are active-high.
- R6: Once running, a low rising undervoltage flag is ignored. Only power-on and the falling flag keep the rails up.
- R7: When power-on falls during normal operation, all rails except converter 1 turn off on the next edge. Converter 1 stays on for D_HOLD ticks and then turns off. A power-on request during that window is ignored, and a new sequence restarts from the first step afterwards.
- R8: If power-on or the falling flag drops mid-sequence, the sequence aborts. Before converter 1 is on, the block goes straight to off; after that, it takes the converter-1 hold path.
- R9: The system reset output goes high only after the sequence has reached linear rail 1 and power-good has been high for D_RST ticks. It goes low at once when power-good falls or the sequence leaves the running state.
- R10: Each select pin is encoded as low=2'b00, open=2'b01, high=2'b10, with 2'b11 read as open. The code 3*a+b is latched on the start edge and held unchanged at all other times.
- R11: The converter fault input turns off both converters while it is high. The linear fault input turns off all four linear rails while it is high. After the linear fault clears, rails 2 to 4 are timed again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base strobe, one clock wide |
| pwr_on | input | 1 | Master power-on request |
| uv_rise_ok | input | 1 | Supply above rising undervoltage limit |
| uv_fall_ok | input | 1 | Supply above falling undervoltage limit |
| ldo1_pg | input | 1 | Linear rail 1 power-good |
| rail2_off | input | 1 | Rail 2 enable, active-low |
| rail3_on | input | 1 | Rail 3 enable |
| rail4_on | input | 1 | Rail 4 enable |
| sel_a | input | 2 | First tri-level select pin |
| sel_b | input | 2 | Second tri-level select pin |
| fault_conv | input | 1 | Converter over-temperature fault |
| fault_lin | input | 1 | Linear-rail over-temperature fault |
| conv1_en | output | 1 | Converter 1 enable |
| conv2_en | output | 1 | Converter 2 enable |
| lin1_en | output | 1 | Linear rail 1 enable |
| lin2_en | output | 1 | Linear rail 2 enable |
| lin3_en | output | 1 | Linear rail 3 enable |
| lin4_en | output | 1 | Linear rail 4 enable |
| sel_code | output | 4 | Latched voltage-select code 0..8 |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
The sequence is exercised in several ways:
- A clean power-up in which power-good is held back, which separates the timed rail order from the power-good gating.
- A start attempt with only the falling undervoltage flag high, which separates the two undervoltage thresholds.
- A power-off followed by an early re-request, which shows that the hold window is not cut short.
- Aborts before and after converter 1 turns on, which separate the direct-off path from the hold path.

Fault pulses on each rail group and changes to the select pins after start-up distinguish combinational gating from latched state.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    PS_OFF  = 3'd0,
    PS_UP1  = 3'd1,
    PS_UP2  = 3'd2,
    PS_UP3  = 3'd3,
    PS_RUN  = 3'd4,
    PS_HOLD = 3'd5
  } pwr_state_e;

  // bits needed for a counter running 0..n-1
  function automatic int unsigned cnt_width(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // tri-level pin weight: low=00 -> 0, high=10 -> 2, open/other -> 1
  function automatic logic [1:0] tri_weight(logic [1:0] pin);
    case (pin)
      2'b00:   return 2'd0;
      2'b10:   return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  function automatic logic [3:0] sel_index(logic [1:0] a, logic [1:0] b);
    return ({2'b00, tri_weight(a)} * 4'd3) + {2'b00, tri_weight(b)};
  endfunction

endpackage

// File: rtl/pwr_delay_gate.sv
module pwr_delay_gate #(
  parameter int unsigned DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic req,
  output logic ready
);
  localparam int unsigned CW = pwr_seq_pkg::cnt_width(DELAY);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!req) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (tick && !done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign ready = req && done_q;
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned D_UP1  = 40,
  parameter int unsigned D_UP2  = 40,
  parameter int unsigned D_UP3  = 65,
  parameter int unsigned D_HOLD = 120
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       pwr_on,
  input  logic       uv_rise_ok,
  input  logic       uv_fall_ok,
  output pwr_state_e state,
  output logic       start_evt
);
  localparam int unsigned MAXD = max2(max2(D_UP1, D_UP2), max2(D_UP3, D_HOLD));
  localparam int unsigned CW   = cnt_width(MAXD);

  pwr_state_e    state_n;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic          timed;
  logic          phase_end;
  logic          run_ok;

  assign run_ok    = pwr_on && uv_fall_ok;
  assign start_evt = (state == PS_OFF) && pwr_on && uv_rise_ok && uv_fall_ok;
  assign timed     = (state == PS_UP1) || (state == PS_UP2) ||
                     (state == PS_UP3) || (state == PS_HOLD);

  always_comb begin
    case (state)
      PS_UP1:  last = CW'(D_UP1 - 1);
      PS_UP2:  last = CW'(D_UP2 - 1);
      PS_UP3:  last = CW'(D_UP3 - 1);
      PS_HOLD: last = CW'(D_HOLD - 1);
      default: last = '0;
    endcase
  end

  assign phase_end = timed && tick && (cnt_q == last);

  always_comb begin
    state_n = state;
    case (state)
      PS_OFF:  if (start_evt) state_n = PS_UP1;
      PS_UP1:  if (!run_ok) state_n = PS_OFF;
               else if (phase_end) state_n = PS_UP2;
      PS_UP2:  if (!run_ok) state_n = PS_HOLD;
               else if (phase_end) state_n = PS_UP3;
      PS_UP3:  if (!run_ok) state_n = PS_HOLD;
               else if (phase_end) state_n = PS_RUN;
      PS_RUN:  if (!run_ok) state_n = PS_HOLD;
      PS_HOLD: if (phase_end) state_n = PS_OFF;
      default: state_n = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PS_OFF;
      cnt_q <= '0;
    end else begin
      state <= state_n;
      if (state_n != state)  cnt_q <= '0;
      else if (timed && tick) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwr_sel_latch.sv
module pwr_sel_latch
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic [1:0] sel_a,
  input  logic [1:0] sel_b,
  output logic [3:0] code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code <= '0;
    else if (capture) code <= sel_index(sel_a, sel_b);
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned D_CONV1 = 40,
  parameter int unsigned D_CONV2 = 40,
  parameter int unsigned D_LIN1  = 65,
  parameter int unsigned D_LIN2  = 45,
  parameter int unsigned D_LIN34 = 15,
  parameter int unsigned D_HOLD  = 120,
  parameter int unsigned D_RST   = 60000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       pwr_on,
  input  logic       uv_rise_ok,
  input  logic       uv_fall_ok,
  input  logic       ldo1_pg,
  input  logic       rail2_off,
  input  logic       rail3_on,
  input  logic       rail4_on,
  input  logic [1:0] sel_a,
  input  logic [1:0] sel_b,
  input  logic       fault_conv,
  input  logic       fault_lin,
  output logic       conv1_en,
  output logic       conv2_en,
  output logic       lin1_en,
  output logic       lin2_en,
  output logic       lin3_en,
  output logic       lin4_en,
  output logic [3:0] sel_code,
  output logic       sys_rst_n
);
  localparam int unsigned N_USER = 3;

  pwr_state_e        state;
  logic              start_evt;
  logic              conv1_live;
  logic              conv2_live;
  logic              seq_running;
  logic              pg_req;
  logic [N_USER-1:0] user_want;
  logic [N_USER-1:0] rail_req;
  logic [N_USER-1:0] rail_en;

  pwr_seq_fsm #(
    .D_UP1 (D_CONV1),
    .D_UP2 (D_CONV2),
    .D_UP3 (D_LIN1),
    .D_HOLD(D_HOLD)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .pwr_on    (pwr_on),
    .uv_rise_ok(uv_rise_ok),
    .uv_fall_ok(uv_fall_ok),
    .state     (state),
    .start_evt (start_evt)
  );

  pwr_sel_latch u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(start_evt),
    .sel_a  (sel_a),
    .sel_b  (sel_b),
    .code   (sel_code)
  );

  assign seq_running = (state == PS_RUN);
  assign conv1_live  = (state == PS_UP2) || (state == PS_UP3) ||
                       seq_running || (state == PS_HOLD);
  assign conv2_live  = (state == PS_UP3) || seq_running;

  assign conv1_en = conv1_live && !fault_conv;
  assign conv2_en = conv2_live && !fault_conv;
  assign lin1_en  = seq_running && !fault_lin;

  // index 0: rail 2 (active-low pin), 1: rail 3, 2: rail 4
  assign user_want = {rail4_on, rail3_on, ~rail2_off};

  for (genvar g = 0; g < N_USER; g++) begin : g_rail
    localparam int unsigned GD = (g == 0) ? D_LIN2 : D_LIN34;
    assign rail_req[g] = lin1_en && ldo1_pg && user_want[g];
    pwr_delay_gate #(.DELAY(GD)) u_gate (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .req  (rail_req[g]),
      .ready(rail_en[g])
    );
  end

  assign lin2_en = rail_en[0];
  assign lin3_en = rail_en[1];
  assign lin4_en = rail_en[2];

  assign pg_req = seq_running && ldo1_pg;

  pwr_delay_gate #(.DELAY(D_RST)) u_rst_gate (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .req  (pg_req),
    .ready(sys_rst_n)
  );
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
  import pwr_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_on,
  input logic       uv_fall_ok,
  input logic       ldo1_pg,
  input logic       fault_conv,
  input logic       start_evt,
  input logic [1:0] sel_a,
  input logic [1:0] sel_b,
  input logic [3:0] sel_code,
  input logic       conv1_en,
  input logic       conv2_en,
  input logic       lin1_en,
  input logic       lin2_en,
  input logic       lin3_en,
  input logic       lin4_en,
  input logic       sys_rst_n
);
  // R3
  conv_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv2_en |-> conv1_en);

  // R4
  rail_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lin2_en || lin3_en || lin4_en) |-> (lin1_en && ldo1_pg));

  // R9
  rst_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_n |-> ldo1_pg);

  // R10
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_evt |=> $stable(sel_code));

  // R10
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (sel_code == sel_index($past(sel_a), $past(sel_b))));

  // R7
  shut_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!(pwr_on && uv_fall_ok)) |->
      (!conv2_en && !lin1_en && !lin2_en && !lin3_en && !lin4_en && !sys_rst_n));

  // R7
  conv1_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(conv1_en) && !fault_conv) |-> (!conv2_en && !lin1_en));
endmodule

bind pwr_seq_ctrl pwr_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_on    (pwr_on),
  .uv_fall_ok(uv_fall_ok),
  .ldo1_pg   (ldo1_pg),
  .fault_conv(fault_conv),
  .start_evt (start_evt),
  .sel_a     (sel_a),
  .sel_b     (sel_b),
  .sel_code  (sel_code),
  .conv1_en  (conv1_en),
  .conv2_en  (conv2_en),
  .lin1_en   (lin1_en),
  .lin2_en   (lin2_en),
  .lin3_en   (lin3_en),
  .lin4_en   (lin4_en),
  .sys_rst_n (sys_rst_n)
);

// File: tb/test_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module test_pwr_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       pwr_on = 1'b0, uv_rise_ok = 1'b0, uv_fall_ok = 1'b0, ldo1_pg = 1'b0;
  logic       rail2_off = 1'b0, rail3_on = 1'b0, rail4_on = 1'b0;
  logic [1:0] sel_a = 2'b01, sel_b = 2'b01;
  logic       fault_conv = 1'b0, fault_lin = 1'b0;
  logic       conv1_en, conv2_en, lin1_en, lin2_en, lin3_en, lin4_en, sys_rst_n;
  logic [3:0] sel_code;
  logic [6:0] obs;

  pwr_seq_ctrl #(
    .D_CONV1(4), .D_CONV2(4), .D_LIN1(6), .D_LIN2(4),
    .D_LIN34(2), .D_HOLD(12), .D_RST(20)
  ) i_pwr_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_on(pwr_on),
    .uv_rise_ok(uv_rise_ok), .uv_fall_ok(uv_fall_ok), .ldo1_pg(ldo1_pg),
    .rail2_off(rail2_off), .rail3_on(rail3_on), .rail4_on(rail4_on),
    .sel_a(sel_a), .sel_b(sel_b), .fault_conv(fault_conv), .fault_lin(fault_lin),
    .conv1_en(conv1_en), .conv2_en(conv2_en), .lin1_en(lin1_en),
    .lin2_en(lin2_en), .lin3_en(lin3_en), .lin4_en(lin4_en),
    .sel_code(sel_code), .sys_rst_n(sys_rst_n)
  );

  // bit order: {sys_rst_n, lin4, lin3, lin2, lin1, conv2, conv1}
  assign obs = {sys_rst_n, lin4_en, lin3_en, lin2_en, lin1_en, conv2_en, conv1_en};

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    ended = 1'b0;
  int    q_cyc[$];
  bit    q_sel[$];
  logic [6:0] q_val[$];
  string q_req[$];

  task automatic exp_out(int c, logic [6:0] v, string r);
    q_cyc.push_back(c); q_sel.push_back(1'b0); q_val.push_back(v); q_req.push_back(r);
  endtask

  task automatic exp_sel(int c, logic [3:0] v, string r);
    q_cyc.push_back(c); q_sel.push_back(1'b1); q_val.push_back({3'b000, v}); q_req.push_back(r);
  endtask

  task automatic at(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // monitor: compare queued expectations away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      for (int i = q_cyc.size() - 1; i >= 0; i--) begin
        if (q_cyc[i] == cyc) begin
          logic [6:0] act;
          act = q_sel[i] ? {3'b000, sel_code} : obs;
          n_vec++;
          if (act !== q_val[i]) begin
            n_bad++;
            $display("FAIL %s cycle %0d %s actual %b expected %b", q_req[i], cyc,
                     q_sel[i] ? "sel_code" : "rails", act, q_val[i]);
          end
          q_cyc.delete(i); q_sel.delete(i); q_val.delete(i); q_req.delete(i);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 3000 && !ended) begin
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected end before 3000", cyc);
      summary();
    end
  end

  // driver
  initial begin
    at(3);
    exp_out(3, 7'b0000000, "R1");
    exp_sel(3, 4'd0, "R1");
    rst_n = 1'b1;
    at(4);
    pwr_on = 1'b1; uv_fall_ok = 1'b1; uv_rise_ok = 1'b0;
    exp_out(11, 7'b0000000, "R2");            // rising flag low: no start
    at(12);
    sel_a = 2'b10; sel_b = 2'b00;             // high, low -> code 6
    rail2_off = 1'b0; rail3_on = 1'b1; rail4_on = 1'b0;
    uv_rise_ok = 1'b1;                        // start edge 13
    exp_sel(14, 4'd6, "R10");
    exp_out(16, 7'b0000000, "R2");
    exp_out(17, 7'b0000001, "R2");
    exp_out(20, 7'b0000001, "R3");
    exp_out(21, 7'b0000011, "R3");
    exp_out(26, 7'b0000011, "R3");
    exp_out(27, 7'b0000111, "R3");
    exp_out(31, 7'b0000111, "R4");            // no power-good yet
    at(32);
    ldo1_pg = 1'b1;
    exp_out(33, 7'b0000111, "R4");
    exp_out(34, 7'b0010111, "R4");            // rail 3 after 2 ticks
    exp_out(35, 7'b0010111, "R5");
    exp_out(36, 7'b0011111, "R5");            // rail 2 (pin low) after 4 ticks
    exp_out(51, 7'b0011111, "R9");
    exp_out(52, 7'b1011111, "R9");
    at(55);
    sel_a = 2'b00; sel_b = 2'b01;             // low, open -> code 1 later
    rail2_off = 1'b1; rail4_on = 1'b1;
    exp_out(55, 7'b1010111, "R5");
    exp_out(56, 7'b1010111, "R5");
    exp_out(57, 7'b1110111, "R5");
    exp_sel(58, 4'd6, "R10");
    at(60);
    uv_rise_ok = 1'b0;
    exp_out(65, 7'b1110111, "R6");
    at(66);
    fault_lin = 1'b1;
    exp_out(66, 7'b1000011, "R11");
    at(68);
    fault_lin = 1'b0;
    exp_out(68, 7'b1000111, "R11");
    exp_out(69, 7'b1000111, "R11");
    exp_out(70, 7'b1110111, "R11");
    at(72);
    fault_conv = 1'b1;
    exp_out(72, 7'b1110100, "R11");
    at(74);
    fault_conv = 1'b0;
    exp_out(74, 7'b1110111, "R11");
    at(80);
    pwr_on = 1'b0;
    exp_out(80, 7'b1110111, "R7");
    exp_out(81, 7'b0000001, "R7");
    exp_out(81, 7'b0000001, "R9");
    at(81);
    ldo1_pg = 1'b0;
    at(85);
    pwr_on = 1'b1; uv_rise_ok = 1'b1;         // request during hold
    exp_out(92, 7'b0000001, "R7");
    exp_out(93, 7'b0000000, "R7");
    exp_sel(95, 4'd1, "R10");
    exp_out(97, 7'b0000000, "R7");
    exp_out(98, 7'b0000001, "R7");
    at(100);
    uv_fall_ok = 1'b0;                        // abort after converter 1
    exp_out(101, 7'b0000001, "R8");
    exp_out(102, 7'b0000001, "R8");
    exp_out(112, 7'b0000001, "R8");
    exp_out(113, 7'b0000000, "R8");
    at(115);
    uv_fall_ok = 1'b1;                        // restart at edge 116
    at(117);
    pwr_on = 1'b0;                            // abort before converter 1
    exp_out(120, 7'b0000000, "R8");
    exp_out(125, 7'b0000000, "R8");
    at(130);
    while (q_cyc.size() != 0) @(negedge clk);
    #8;
    summary();
  end
endmodule